// File: doc/BRIEF.md
# Test Access Port with Addressed Configuration Registers

This block is a four-wire serial test port. It lets an external controller read and write a bank of internal configuration registers. The standard 16-state tap controller is clocked by the test clock and steered by the mode-select line. Scan operations move a 6-bit instruction into an instruction register. The instruction then picks one data register for the following data scans: a 32-bit fixed identity word, a one-bit pass-through cell, a boundary stub over simple parallel pin vectors, or a single 16-bit shift register that all configuration registers share.

Instructions whose top bit is one carry a 5-bit register address. A data scan under such an instruction reads the addressed register and returns it on the serial output. At the same time it receives a new value, which is written back to that register when the scan completes. The whole bank is visible at all times on a flat parallel output for the surrounding logic. The serial output changes on the falling edge of the test clock. Inputs are consumed on the rising edge.

Top module: `jtag_regprog_tap`

## Requirements
- R1: An active-low asynchronous reset `trst_n` forces the controller into Test-Logic-Reset, which loads the identity instruction (011111). The same reset clears every configuration register to zero, clears the boundary update latch to zero and drives `tdo` high. This holds even when the reset arrives in the middle of a data scan.
- R2: Under instruction 011111 a data scan returns the 32-bit identity value, least significant bit first. The bits shifted in on `tdi` never change the value returned by later identity scans.
- R3: An instruction scan shifts the new opcode in least significant bit first and returns the fixed capture pattern 000001. The new opcode takes effect on the falling clock edge in Update-IR.
- R4: Instruction 1aaaaa, with a in 0..30, selects configuration register a. Capture-DR loads that register's 16-bit value into the shared shift register, which shifts least significant bit first. The falling edge in Update-DR writes the shifted value back to register a only. Register a appears on `cfg_q[16a+15:16a]`.
- R5: Instruction 111111 selects the one-bit pass-through cell, which captures 0. The scan output is the input delayed by one bit, with a leading 0. `cfg_q` and `pin_out` are not affected by the scan.
- R6: Opcodes other than 000000, 000001, 011111 and 1aaaaa (a in 0..30) behave exactly like 111111.
- R7: Under instruction 000000, Capture-DR loads `pin_in` into the boundary chain, with bit 0 nearest `tdo`. `pin_out` is driven from the boundary update latch, and that latch changes only on the falling edge in Update-DR.
- R8: Under instruction 000001, Capture-DR loads `pin_in` and Update-DR preloads the update latch. `pin_out` keeps following `core_out` whenever the active instruction is not 000000. A later switch to 000000 drives the preloaded value.
- R9: Five consecutive rising clock edges with `tms` high bring the controller to Test-Logic-Reset from any state. This reloads the identity instruction and leaves the configuration registers unchanged.
- R10: `tdo` carries the selected register's low bit only while the controller is in Shift-DR or Shift-IR. It is updated on the falling clock edge and is held high in every other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| pin_in | input | BS_W | Pin values captured by the boundary chain |
| core_out | input | BS_W | Functional values for the output pins |
| pin_out | output | BS_W | Output pins: update latch under 000000, else `core_out` |
| cfg_q | output | NREG*CFG_W | All configuration registers, register a at bits [CFG_W*a +: CFG_W] |

## Verification
A data scan takes three clock cycles from Run-Test-Idle to the first shift cycle, then one cycle per bit, then two cycles back to Run-Test-Idle. A bit placed on `tdi` in one shift cycle therefore reappears on `tdo` at the falling edge of the next cycle through the one-bit cell. Writes to a register, the update latch or the instruction land on the falling edge inside the Update state. The bench drives `tms`/`tdi` just after each rising edge and reads `tdo` just after each falling edge. It checks `cfg_q` and `pin_out` only once the Update cycle has closed, which is after the last step of a scan task.

// File: rtl/jtag_rp_pkg.sv
package jtag_rp_pkg;

   localparam int IR_W   = 6;
   localparam int ADDR_W = 5;

   localparam logic [IR_W-1:0] OP_EXTEST = 6'b000000;
   localparam logic [IR_W-1:0] OP_SAMPLE = 6'b000001;
   localparam logic [IR_W-1:0] OP_IDENT  = 6'b011111;
   localparam logic [IR_W-1:0] OP_PASS   = 6'b111111;
   localparam logic [IR_W-1:0] IR_CAPT   = 6'b000001;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_t;

   typedef struct packed {
      logic extest;
      logic sample;
      logic ident;
      logic regprog;
      logic pass;
   } dr_sel_t;

   function automatic tap_st_t tap_next(tap_st_t s, logic m);
      tap_st_t n;
      case (s)
         ST_TLR:    n = m ? ST_TLR    : ST_RTI;
         ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
         default:   n = ST_TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtag_rp_fsm.sv
module jtag_rp_fsm
   import jtag_rp_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_t st
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= tap_next(st, tms);
   end

   // checker-only run length of consecutive tms-high edges
   logic [2:0] ones_cnt;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               ones_cnt <= 3'd0;
      else if (!tms)             ones_cnt <= 3'd0;
      else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
   end

   // R9
   tlr_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_cnt == 3'd5) |-> (st == ST_TLR));

endmodule

// File: rtl/jtag_rp_ir.sv
module jtag_rp_ir
   import jtag_rp_pkg::*;
#(
   parameter int NREG = 31
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tdi,
   input  tap_st_t           st,
   output logic              ir_lsb,
   output dr_sel_t           sel,
   output logic [ADDR_W-1:0] addr
);

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] ir;
   logic            addr_ok;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)              ir_sh <= IR_CAPT;
      else if (st == ST_CAP_IR) ir_sh <= IR_CAPT;
      else if (st == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)              ir <= OP_IDENT;
      else if (st == ST_TLR)    ir <= OP_IDENT;
      else if (st == ST_UPD_IR) ir <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];
   assign addr   = ir[ADDR_W-1:0];

   generate
      if (NREG >= (1 << ADDR_W) - 1) begin : g_full_map
         assign addr_ok = 1'b1;
      end else begin : g_part_map
         assign addr_ok = ({{(32-ADDR_W){1'b0}}, addr} < NREG);
      end
   endgenerate

   always_comb begin
      sel = '0;
      if (ir == OP_EXTEST)                            sel.extest  = 1'b1;
      else if (ir == OP_SAMPLE)                       sel.sample  = 1'b1;
      else if (ir == OP_IDENT)                        sel.ident   = 1'b1;
      else if (ir[IR_W-1] && ir != OP_PASS && addr_ok) sel.regprog = 1'b1;
      else                                            sel.pass    = 1'b1;
   end

   // R6
   sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $countones(sel) == 1);

   // R1
   ir_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |-> (ir == OP_IDENT));

endmodule

// File: rtl/jtag_rp_cfg.sv
module jtag_rp_cfg
   import jtag_rp_pkg::*;
#(
   parameter int              NREG    = 31,
   parameter int              CFG_W   = 16,
   parameter logic [CFG_W-1:0] CFG_RST = '0
) (
   input  logic                  tck,
   input  logic                  trst_n,
   input  logic                  tdi,
   input  tap_st_t               st,
   input  logic                  regprog,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  sh_lsb,
   output logic [NREG*CFG_W-1:0] cfg_q
);

   logic [CFG_W-1:0] bank [NREG];
   logic [CFG_W-1:0] sh;
   logic [CFG_W-1:0] rd;

   always_comb begin
      rd = '0;
      for (int i = 0; i < NREG; i++)
         if (addr == ADDR_W'(i)) rd = bank[i];
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                           sh <= '0;
      else if (regprog && st == ST_CAP_DR)   sh <= rd;
      else if (regprog && st == ST_SH_DR)    sh <= {tdi, sh[CFG_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         for (int i = 0; i < NREG; i++) bank[i] <= CFG_RST;
      end else if (regprog && st == ST_UPD_DR) begin
         for (int i = 0; i < NREG; i++)
            if (addr == ADDR_W'(i)) bank[i] <= sh;
      end
   end

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_flat
         assign cfg_q[g*CFG_W +: CFG_W] = bank[g];
      end
   endgenerate

   assign sh_lsb = sh[0];

   // R4
   cfg_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_UPD_DR || !regprog) |-> $stable(cfg_q));

endmodule

// File: rtl/jtag_regprog_tap.sv
module jtag_regprog_tap
   import jtag_rp_pkg::*;
#(
   parameter int               NREG     = 31,
   parameter int               CFG_W    = 16,
   parameter int               BS_W     = 8,
   parameter logic [31:0]      ID_VALUE = 32'h4B1D_2A57,
   parameter logic [CFG_W-1:0] CFG_RST  = '0
) (
   input  logic                  tck,
   input  logic                  trst_n,
   input  logic                  tms,
   input  logic                  tdi,
   output logic                  tdo,
   input  logic [BS_W-1:0]       pin_in,
   input  logic [BS_W-1:0]       core_out,
   output logic [BS_W-1:0]       pin_out,
   output logic [NREG*CFG_W-1:0] cfg_q
);

   localparam int ID_W = 32;

   generate
      if (NREG < 1 || NREG > (1 << ADDR_W) - 1) begin : g_bad_nreg
         $error("NREG must lie in 1..31");
      end
      if (CFG_W < 2) begin : g_bad_cfgw
         $error("CFG_W must be at least 2");
      end
      if (BS_W < 2) begin : g_bad_bsw
         $error("BS_W must be at least 2");
      end
   endgenerate

   tap_st_t           st;
   dr_sel_t           sel;
   logic [ADDR_W-1:0] addr;
   logic              ir_lsb;
   logic              cfg_lsb;

   jtag_rp_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   jtag_rp_ir #(.NREG(NREG)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .st     (st),
      .ir_lsb (ir_lsb),
      .sel    (sel),
      .addr   (addr)
   );

   jtag_rp_cfg #(.NREG(NREG), .CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .st      (st),
      .regprog (sel.regprog),
      .addr    (addr),
      .sh_lsb  (cfg_lsb),
      .cfg_q   (cfg_q)
   );

   logic [ID_W-1:0] id_sh;
   logic            pass_q;
   logic [BS_W-1:0] bs_sh;
   logic [BS_W-1:0] bs_upd;
   logic            bs_sel;

   assign bs_sel = sel.extest | sel.sample;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sh  <= '0;
         pass_q <= 1'b0;
         bs_sh  <= '0;
      end else if (st == ST_CAP_DR) begin
         if (sel.ident) id_sh  <= ID_VALUE;
         if (sel.pass)  pass_q <= 1'b0;
         if (bs_sel)    bs_sh  <= pin_in;
      end else if (st == ST_SH_DR) begin
         if (sel.ident) id_sh  <= {tdi, id_sh[ID_W-1:1]};
         if (sel.pass)  pass_q <= tdi;
         if (bs_sel)    bs_sh  <= {tdi, bs_sh[BS_W-1:1]};
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                        bs_upd <= '0;
      else if (bs_sel && st == ST_UPD_DR) bs_upd <= bs_sh;
   end

   assign pin_out = sel.extest ? bs_upd : core_out;

   logic dr_lsb;
   always_comb begin
      dr_lsb = pass_q;
      if (sel.ident)   dr_lsb = id_sh[0];
      if (bs_sel)      dr_lsb = bs_sh[0];
      if (sel.regprog) dr_lsb = cfg_lsb;
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)              tdo <= 1'b1;
      else if (st == ST_SH_DR)  tdo <= dr_lsb;
      else if (st == ST_SH_IR)  tdo <= ir_lsb;
      else                      tdo <= 1'b1;
   end

   // R10
   tdo_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_SH_DR && st != ST_SH_IR) |-> tdo);

   // R5
   pass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_DR && sel.pass) |=> (pass_q == 1'b0));

   // R7
   pin_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel.extest && $past(sel.extest) && st != ST_UPD_DR) |-> $stable(pin_out));

endmodule

// File: tb/jtag_regprog_tap_bench.sv
module jtag_regprog_tap_bench;

   localparam int          NREG  = 31;
   localparam int          CFG_W = 16;
   localparam int          BS_W  = 8;
   localparam logic [31:0] ID    = 32'h4B1D_2A57;

   logic                  tck = 1'b0;
   logic                  trst_n = 1'b0;
   logic                  tms = 1'b1;
   logic                  tdi = 1'b0;
   logic                  tdo;
   logic [BS_W-1:0]       pin_in = '0;
   logic [BS_W-1:0]       core_out = '0;
   logic [BS_W-1:0]       pin_out;
   logic [NREG*CFG_W-1:0] cfg_q;

   jtag_regprog_tap #(.NREG(NREG), .CFG_W(CFG_W), .BS_W(BS_W), .ID_VALUE(ID)) u_jtag_regprog_tap (
      .tck      (tck),
      .trst_n   (trst_n),
      .tms      (tms),
      .tdi      (tdi),
      .tdo      (tdo),
      .pin_in   (pin_in),
      .core_out (core_out),
      .pin_out  (pin_out),
      .cfg_q    (cfg_q)
   );

   always #4 tck = ~tck;

   int n_chk = 0;
   int n_bad = 0;
   int idle_bad = 0;
   logic [CFG_W-1:0] mdl [NREG];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_bank(input string tag);
      for (int i = 0; i < NREG; i++)
         check(tag, {16'd0, cfg_q[i*CFG_W +: CFG_W]}, {16'd0, mdl[i]});
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      tms = m;
      tdi = d;
      @(negedge tck); #1;
      o = tdo;
      @(posedge tck); #1;
   endtask

   task automatic idle_step(input logic m);
      logic o;
      step(m, 1'b0, o);
      if (o !== 1'b1) idle_bad++;
   endtask

   task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap);
      logic o;
      idle_step(1'b1);
      idle_step(1'b1);
      idle_step(1'b0);
      idle_step(1'b0);
      for (int i = 0; i < 6; i++) begin
         step(i == 5, op[i], o);
         cap[i] = o;
      end
      idle_step(1'b1);
      idle_step(1'b0);
   endtask

   task automatic scan_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
      logic o;
      dout = '0;
      idle_step(1'b1);
      idle_step(1'b0);
      idle_step(1'b0);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
      end
      idle_step(1'b1);
      idle_step(1'b0);
   endtask

   task automatic load_ir(input logic [5:0] op);
      logic [5:0] cap;
      scan_ir(op, cap);
      check("R3 capture pattern", {26'd0, cap}, 32'h1);
   endtask

   function automatic logic [15:0] pat_a(input int a);
      return 16'((a * 16'h0B37) ^ 16'h5A5A);
   endfunction

   function automatic logic [15:0] pat_b(input int a);
      return 16'(~pat_a(a) ^ (a << 3));
   endfunction

   initial begin
      repeat (150000) @(posedge tck);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [5:0]  undef_ops [4];
      undef_ops[0] = 6'b000010;
      undef_ops[1] = 6'b010000;
      undef_ops[2] = 6'b011110;
      undef_ops[3] = 6'b001111;
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
      core_out = 8'h3C;

      // R1 reset state
      repeat (3) @(posedge tck);
      #1 trst_n = 1'b1;
      check("R1 tdo after reset", {31'd0, tdo}, 32'h1);
      check("R1 pin_out follows core", {24'd0, pin_out}, {24'd0, core_out});
      check_bank("R1 bank cleared");
      idle_step(1'b0);

      // R1 / R2 identity instruction active after reset, shifting does not alter it
      scan_dr(32'hFFFF_FFFF, 32, d);
      check("R2 identity first read", d, ID);
      scan_dr(32'h1234_8765, 32, d);
      check("R2 identity second read", d, ID);

      // R4 sweep all addresses: write, then rewrite with readback
      for (int a = 0; a < NREG; a++) begin
         load_ir({1'b1, 5'(a)});
         scan_dr({16'd0, pat_a(a)}, 16, d);
         check("R4 first readback", {16'd0, d[15:0]}, {16'd0, mdl[a]});
         mdl[a] = pat_a(a);
         check("R4 written slice", {16'd0, cfg_q[a*CFG_W +: CFG_W]}, {16'd0, mdl[a]});
      end
      check_bank("R4 bank after pass one");
      for (int a = NREG - 1; a >= 0; a--) begin
         load_ir({1'b1, 5'(a)});
         scan_dr({16'd0, pat_b(a)}, 16, d);
         check("R4 second readback", {16'd0, d[15:0]}, {16'd0, mdl[a]});
         mdl[a] = pat_b(a);
      end
      check_bank("R4 bank after pass two");

      // R5 pass-through opcode 111111
      load_ir(6'b111111);
      scan_dr(32'h0000_B4E1, 16, d);
      check("R5 one-bit delay", {16'd0, d[15:0]}, {16'd0, 16'hB4E1 << 1});
      check_bank("R5 bank untouched");
      check("R5 pin_out untouched", {24'd0, pin_out}, {24'd0, core_out});

      // R6 undefined opcodes
      for (int k = 0; k < 4; k++) begin
         load_ir(undef_ops[k]);
         scan_dr(32'h0000_0093 ^ k, 8, d);
         check("R6 undefined acts as pass", {24'd0, d[7:0]}, {24'd0, 8'((8'h93 ^ k) << 1)});
         check_bank("R6 bank untouched");
      end

      // R7 boundary drive
      pin_in = 8'hA6;
      check("R8 pin_out before boundary mode", {24'd0, pin_out}, 32'h3C);
      load_ir(6'b000000);
      check("R7 reset update latch", {24'd0, pin_out}, 32'h00);
      scan_dr(32'h0000_005D, 8, d);
      check("R7 pins captured", {24'd0, d[7:0]}, 32'hA6);
      check("R7 pins driven", {24'd0, pin_out}, 32'h5D);
      core_out = 8'h81;
      #2;
      check("R7 core ignored in boundary mode", {24'd0, pin_out}, 32'h5D);

      // R8 sample and preload
      pin_in = 8'h71;
      load_ir(6'b000001);
      check("R8 pin_out follows core", {24'd0, pin_out}, 32'h81);
      scan_dr(32'h0000_00C9, 8, d);
      check("R8 sample capture", {24'd0, d[7:0]}, 32'h71);
      check("R8 preload not driven", {24'd0, pin_out}, 32'h81);
      core_out = 8'hE2;
      #2;
      check("R8 core tracked", {24'd0, pin_out}, 32'hE2);
      load_ir(6'b000000);
      check("R8 preloaded value driven", {24'd0, pin_out}, 32'hC9);
      load_ir(6'b111111);
      check("R8 core again after leaving", {24'd0, pin_out}, 32'hE2);

      // R9 five tms-high edges reach reset state
      for (int i = 0; i < 5; i++) idle_step(1'b1);
      idle_step(1'b0);
      scan_dr(32'h0, 32, d);
      check("R9 identity after tms reset", d, ID);
      check_bank("R9 bank retained");

      // R1 asynchronous reset in mid scan
      load_ir({1'b1, 5'd7});
      idle_step(1'b1);
      idle_step(1'b0);
      idle_step(1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, d[0]);
      trst_n = 1'b0;
      #1;
      check("R1 tdo on async reset", {31'd0, tdo}, 32'h1);
      check("R1 update latch cleared", {24'd0, pin_out}, {24'd0, core_out});
      @(posedge tck); #1;
      trst_n = 1'b1;
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
      check_bank("R1 bank cleared mid scan");
      idle_step(1'b0);
      scan_dr(32'hA5A5_A5A5, 32, d);
      check("R1 identity after async reset", d, ID);

      // R10 tdo high outside shift states throughout the run
      check("R10 idle tdo high", idle_bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule